// File: doc/BRIEF.md
# Counter Gate Control Sequencer

This block produces the control signals for a gated event counter: a clear strobe for the count chain, the gate window during which events are counted, an inverted copy of the gate for an indicator, and a latch strobe that moves the finished count into a display register. It runs in the system clock domain. A slow reference square wave (nominally 1 MHz) is synchronised on its way in. Every falling edge of that reference becomes a one-cycle tick, and every output change is lined up on a tick.

In automatic mode the sequencer repeats one cycle. It holds clear for one reference period. It then starts a decade time base from a preset in which every digit below the top one is 9 and the top digit is 0. The first carry from the selected decade arms the gate, and the gate opens on the following tick. The next carry from that decade arms closing, and the gate closes on the tick after that. Closing fires a one-period latch strobe and starts the display hold. The hold length is a count of millisecond units, with all ones meaning hold forever. When the hold runs out, the next cycle starts with clear. In manual mode the latch is held high, the gate follows a start level, and a reset level drives clear. Both levels are sampled on ticks.

States: `ST_CLEAR` goes to `ST_WAIT_OPEN` on a tick. `ST_WAIT_OPEN` goes to `ST_PEND_OPEN` on a tap carry. `ST_PEND_OPEN` goes to `ST_GATE` on a tick. `ST_GATE` goes to `ST_PEND_CLOSE` on a tap carry. `ST_PEND_CLOSE` goes to `ST_LATCH` on a tick. `ST_LATCH` goes to `ST_HOLD` on a tick. `ST_HOLD` goes to `ST_CLEAR` on a tick once the hold has expired. Every state goes to `ST_MANUAL` while `manual` is high, and `ST_MANUAL` goes to `ST_CLEAR` once `manual` drops. A synchronous reset enters `ST_CLEAR`.

Top module: `gate_seq_ctrl`

## Requirements
- R1: While and directly after synchronous reset: clear=1, gate=0, latch=0, gate_n=1.
- R2: In automatic mode, clear lasts exactly one reference period (one tick to the next).
- R3: The gate opens exactly two reference periods after clear falls. One period is the preset time-base carry and one is the resync tick.
- R4: The gate stays open for exactly 10^(sel+1) reference periods. A sel value above NDEC-2 is treated as NDEC-2.
- R5: latch rises on the same clock edge as the gate falls and lasts exactly one reference period in automatic mode.
- R6: With hold code N (not all ones), clear rises max(2, N*MS_TICKS+1) reference periods after the gate falls.
- R7: A hold code of all ones stops the cycle after the latch strobe, with clear, gate and latch all low. Changing the code to a finite value while waiting resumes the cycle within one tick.
- R8: In manual mode latch is high continuously, gate follows start, and clear follows man_reset, each sampled on a tick.
- R9: Dropping manual enters clear on the next clock, and the automatic cycle then proceeds with R3 timing.
- R10: gate_n is always the inverse of gate.
- R11: Outside manual-mode transitions, gate changes only on the clock after a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_clk | input | 1 | Reference square wave; each falling edge is one tick |
| manual | input | 1 | 1 = manual mode |
| start | input | 1 | Manual gate level (1 = open) |
| man_reset | input | 1 | Manual clear level |
| sel | input | SELW | Decade tap select: interval of 10^(sel+1) ticks |
| hold_cnt | input | HW | Display hold in units of MS_TICKS ticks; all ones = hold forever |
| clear | output | 1 | Count-chain clear strobe |
| gate | output | 1 | Count window |
| gate_n | output | 1 | Inverted gate for an indicator |
| latch | output | 1 | Display-register load strobe |

## Verification
A wrong state register shows up as a wrong pulse width on the ports. A skipped pend state makes the clear-to-gate gap one period too short. A bad tap index changes the gate width by a factor of ten. A broken hold timer moves the next clear rise by multiples of MS_TICKS periods. A wrong time-base preset shows within the first gate window of a cycle, and a wrong hold count shows in the gap before the next clear. Manual-mode errors show within two ticks as a gate or clear that does not follow its input.

// File: rtl/gate_seq_pkg.sv
package gate_seq_pkg;
    typedef enum logic [2:0] {
        ST_CLEAR,
        ST_WAIT_OPEN,
        ST_PEND_OPEN,
        ST_GATE,
        ST_PEND_CLOSE,
        ST_LATCH,
        ST_HOLD,
        ST_MANUAL
    } seq_state_t;

    typedef logic [3:0] bcd_digit_t;
endpackage

// File: rtl/gate_seq_refedge.sv
module gate_seq_refedge #(
    parameter int SYNC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_clk,
    output logic tick
);
    logic [SYNC:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) shreg <= '0;
        else     shreg <= {shreg[SYNC-1:0], ref_clk};
    end

    // falling edge of the synchronised reference
    assign tick = shreg[SYNC] & ~shreg[SYNC-1];
endmodule

// File: rtl/gate_seq_timebase.sv
module gate_seq_timebase
    import gate_seq_pkg::*;
#(
    parameter int NDEC = 7,
    parameter int SELW = $clog2(NDEC)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic            step,
    input  logic [SELW-1:0] sel,
    output logic            tap
);
    localparam int MAXSEL = NDEC - 2;

    bcd_digit_t       dig [NDEC];
    logic [NDEC-1:0]  cy;
    logic [SELW-1:0]  sel_eff;
    logic [SELW-1:0]  tidx;

    assign cy[0] = step;

    for (genvar g = 0; g < NDEC; g++) begin : g_dig
        if (g < NDEC - 1) begin : g_cy
            assign cy[g+1] = cy[g] && (dig[g] == 4'd9);
        end
        always_ff @(posedge clk) begin
            if (rst || load)
                dig[g] <= (g == NDEC - 1) ? 4'd0 : 4'd9;
            else if (cy[g])
                dig[g] <= (dig[g] == 4'd9) ? 4'd0 : dig[g] + 4'd1;
        end
    end

    always_comb begin
        sel_eff = (sel > SELW'(MAXSEL)) ? SELW'(MAXSEL) : sel;
        tidx    = sel_eff + SELW'(1);
        tap     = cy[tidx];
    end
endmodule

// File: rtl/gate_seq_holdtmr.sv
module gate_seq_holdtmr #(
    parameter int MS_TICKS = 1000,
    parameter int HW       = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          step,
    input  logic [HW-1:0] hold_cnt,
    output logic          expired
);
    localparam int PW = (MS_TICKS > 1) ? $clog2(MS_TICKS) : 1;

    logic [PW-1:0] sub;
    logic [HW-1:0] units;
    logic          frozen;

    always_ff @(posedge clk) begin
        if (rst || start) begin
            sub   <= '0;
            units <= '0;
        end else if (step) begin
            if (sub == PW'(MS_TICKS - 1)) begin
                sub <= '0;
                if (units != '1) units <= units + HW'(1);
            end else begin
                sub <= sub + PW'(1);
            end
        end
    end

    assign frozen  = (hold_cnt == '1);
    assign expired = !frozen && (units >= hold_cnt);
endmodule

// File: rtl/gate_seq_ctrl.sv
module gate_seq_ctrl
    import gate_seq_pkg::*;
#(
    parameter int NDEC     = 7,
    parameter int SELW     = $clog2(NDEC),
    parameter int MS_TICKS = 1000,
    parameter int HW       = 8,
    parameter int SYNC     = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ref_clk,
    input  logic            manual,
    input  logic            start,
    input  logic            man_reset,
    input  logic [SELW-1:0] sel,
    input  logic [HW-1:0]   hold_cnt,
    output logic            clear,
    output logic            gate,
    output logic            gate_n,
    output logic            latch
);
    seq_state_t state, nxt;
    logic tick, tap, expired, counting;
    logic man_gate, man_clr;

    gate_seq_refedge #(.SYNC(SYNC)) edge_i (
        .clk(clk), .rst(rst), .ref_clk(ref_clk), .tick(tick)
    );

    assign counting = (state == ST_WAIT_OPEN) || (state == ST_PEND_OPEN) ||
                      (state == ST_GATE)      || (state == ST_PEND_CLOSE);

    gate_seq_timebase #(.NDEC(NDEC), .SELW(SELW)) tb_i (
        .clk(clk), .rst(rst), .load(!counting),
        .step(tick && counting), .sel(sel), .tap(tap)
    );

    gate_seq_holdtmr #(.MS_TICKS(MS_TICKS), .HW(HW)) hold_i (
        .clk(clk), .rst(rst),
        .start(tick && (state == ST_PEND_CLOSE)),
        .step(tick && ((state == ST_LATCH) || (state == ST_HOLD))),
        .hold_cnt(hold_cnt), .expired(expired)
    );

    always_comb begin
        nxt = state;
        if (manual) begin
            nxt = ST_MANUAL;
        end else begin
            unique case (state)
                ST_CLEAR:      if (tick) nxt = ST_WAIT_OPEN;
                ST_WAIT_OPEN:  if (tap)  nxt = ST_PEND_OPEN;
                ST_PEND_OPEN:  if (tick) nxt = ST_GATE;
                ST_GATE:       if (tap)  nxt = ST_PEND_CLOSE;
                ST_PEND_CLOSE: if (tick) nxt = ST_LATCH;
                ST_LATCH:      if (tick) nxt = ST_HOLD;
                ST_HOLD:       if (tick && expired) nxt = ST_CLEAR;
                ST_MANUAL:     nxt = ST_CLEAR;
                default:       nxt = ST_CLEAR;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_CLEAR;
        else     state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (rst || (state != ST_MANUAL)) begin
            man_gate <= 1'b0;
            man_clr  <= 1'b0;
        end else if (tick) begin
            man_gate <= start;
            man_clr  <= man_reset;
        end
    end

    always_comb begin
        clear = 1'b0;
        gate  = 1'b0;
        latch = 1'b0;
        unique case (state)
            ST_CLEAR:      clear = 1'b1;
            ST_GATE,
            ST_PEND_CLOSE: gate  = 1'b1;
            ST_LATCH:      latch = 1'b1;
            ST_MANUAL: begin
                latch = 1'b1;
                gate  = man_gate;
                clear = man_clr;
            end
            default: ;
        endcase
        gate_n = ~gate;
    end
endmodule

// File: rtl/gate_seq_ctrl_chk.sv
module gate_seq_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic manual,
    input logic tick,
    input logic clear,
    input logic gate,
    input logic gate_n,
    input logic latch
);
    // R10
    gate_inv_chk: assert property (@(posedge clk) disable iff (rst)
        gate_n == !gate);

    // R11
    gate_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (gate != $past(gate)) && !manual && !$past(manual) |-> $past(tick));

    // R5
    latch_one_period_chk: assert property (@(posedge clk) disable iff (rst || manual)
        latch && tick |=> !latch);

    // R5
    latch_at_close_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(latch) && !$past(manual) |-> $fell(gate));

    // R2
    clear_gate_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !manual && !$past(manual) |-> !(clear && gate));

    // R8
    manual_latch_chk: assert property (@(posedge clk) disable iff (rst)
        manual && $past(manual) |-> latch);
endmodule

bind gate_seq_ctrl gate_seq_ctrl_chk chk_i (
    .clk(clk), .rst(rst), .manual(manual), .tick(tick),
    .clear(clear), .gate(gate), .gate_n(gate_n), .latch(latch)
);

// File: tb/gate_seq_ctrl_tb_top.sv
module gate_seq_ctrl_tb_top;
    localparam int NDEC = 4;
    localparam int SELW = 2;
    localparam int MS   = 5;
    localparam int HW   = 8;
    localparam int PER  = 4;   // clocks per reference period

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_clk = 1'b0;
    logic manual = 1'b0, start = 1'b0, man_reset = 1'b0;
    logic [SELW-1:0] sel = '0;
    logic [HW-1:0]   hold_cnt = '0;
    logic clear, gate, gate_n, latch;
    int checks = 0, errors = 0;

    always #2 clk = ~clk;

    initial forever begin
        repeat (2) @(posedge clk);
        ref_clk <= ~ref_clk;
    end

    gate_seq_ctrl #(.NDEC(NDEC), .SELW(SELW), .MS_TICKS(MS), .HW(HW)) dut_i (
        .clk(clk), .rst(rst), .ref_clk(ref_clk), .manual(manual),
        .start(start), .man_reset(man_reset), .sel(sel), .hold_cnt(hold_cnt),
        .clear(clear), .gate(gate), .gate_n(gate_n), .latch(latch)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int pow10(input int n);
        int v = 1;
        for (int i = 0; i < n; i++) v = v * 10;
        return v;
    endfunction

    // R1
    task automatic t_reset();
        rst = 1'b1;
        repeat (5) @(negedge clk);
        check(clear && !gate && !latch && gate_n, "R1", "outputs in reset",
              {clear, gate, latch, gate_n}, 4'b1001);
        rst = 1'b0;
        @(negedge clk);
        check(clear && !gate && !latch && gate_n, "R1", "outputs after reset",
              {clear, gate, latch, gate_n}, 4'b1001);
        while (clear) @(negedge clk);
    endtask

    // R2 R3 R4 R5 R6 R10 R11
    task automatic t_auto(input int s, input int n);
        int w = 0, c = 0, g = 0, l = 0, d = 0, se, hexp;
        bit inv_ok = 1'b1;
        sel = SELW'(s);
        hold_cnt = HW'(n);
        se = (s > NDEC - 2) ? NDEC - 2 : s;
        hexp = (n * MS + 1 > 2) ? n * MS + 1 : 2;
        while (!clear) @(negedge clk);
        while (clear) begin w++; @(negedge clk); end
        check(w == PER, "R2", "clear width", w, PER);
        while (!gate) begin c++; @(negedge clk); end
        check(c == 2 * PER, "R3", "clear fall to gate rise", c, 2 * PER);
        while (gate) begin
            if (gate_n != !gate) inv_ok = 1'b0;
            g++;
            @(negedge clk);
        end
        check(g == PER * pow10(se + 1), "R4", "gate width (R11 tick multiple)",
              g, PER * pow10(se + 1));
        check(inv_ok && gate_n, "R10", "gate_n inverse", int'(gate_n), 1);
        check(latch == 1'b1, "R5", "latch at gate close", int'(latch), 1);
        while (latch) begin l++; @(negedge clk); end
        check(l == PER, "R5", "latch width", l, PER);
        d = l;
        while (!clear) begin d++; @(negedge clk); end
        check(d == PER * hexp, "R6", "gate fall to next clear", d, PER * hexp);
    endtask

    // R7
    task automatic t_freeze();
        bit quiet = 1'b1;
        int k = 0;
        sel = '0;
        hold_cnt = '1;
        while (!gate) @(negedge clk);
        while (gate) @(negedge clk);
        repeat (2 * PER) @(negedge clk);
        repeat (3000) begin
            if (clear || gate || latch) quiet = 1'b0;
            @(negedge clk);
        end
        check(quiet, "R7", "frozen hold stays idle", int'(quiet), 1);
        hold_cnt = HW'(1);
        while (!clear && k < 100) begin k++; @(negedge clk); end
        check(clear && k <= 2 * PER, "R7", "resume after hold change", k, 2 * PER);
    endtask

    // R8 R9
    task automatic t_manual();
        int c = 0;
        @(negedge clk);
        manual = 1'b1;
        repeat (2) @(negedge clk);
        check(latch == 1'b1, "R8", "latch held in manual", int'(latch), 1);
        start = 1'b1;
        repeat (3 * PER) @(negedge clk);
        check(gate && !gate_n && latch, "R8", "gate follows start",
              {gate, gate_n, latch}, 3'b101);
        man_reset = 1'b1;
        repeat (3 * PER) @(negedge clk);
        check(clear == 1'b1, "R8", "clear follows man_reset", int'(clear), 1);
        man_reset = 1'b0;
        repeat (3 * PER) @(negedge clk);
        check(clear == 1'b0, "R8", "clear released", int'(clear), 0);
        start = 1'b0;
        repeat (3 * PER) @(negedge clk);
        check(!gate && latch, "R8", "gate closed by stop", {gate, latch}, 2'b01);
        manual = 1'b0;
        @(negedge clk);
        check(clear && !latch && !gate, "R9", "clear on manual exit",
              {clear, latch, gate}, 3'b100);
        while (clear) @(negedge clk);
        while (!gate) begin c++; @(negedge clk); end
        check(c == 2 * PER, "R9", "gate opens after manual exit", c, 2 * PER);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_auto(0, 0);
        t_auto(1, 3);
        t_auto(2, 1);
        t_auto(3, 0);   // R4 clamp: sel 3 acts as 2
        t_freeze();
        t_auto(0, 2);
        t_manual();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule